// File: doc/BRIEF.md
# Zero-Crossing Line Frequency Estimator

This block estimates the mains line frequency from a stream of signed voltage samples. The samples arrive at a fixed output word rate, and a valid strobe marks each one. The block waits for a reference zero crossing. It then counts a programmable number N of further crossings and, over the same window, counts the valid samples S. Each crossing marks one half period, so the ratio of line frequency to sample rate is N / (2·S). A bit-serial restoring divider computes this ratio as a 24-bit unsigned fraction.

When the division finishes, a result inside the supported 40 Hz to 75 Hz band is written to the epsilon output and sets a sticky update flag. A result outside that band leaves epsilon as it was and sets a sticky out-of-range flag. Software clears each flag by pulsing its clear input, which has the effect of writing a 1 to the flag. While the enable input is low, no measurement runs and epsilon holds its value. Writing the crossing count, or toggling the enable, throws away the window in progress and starts a new one. A downstream quadrature filter uses epsilon as a gain. Until the first measurement, epsilon keeps the value for 50 Hz at 4000 samples per second.

Top module: `line_freq_est`

## Requirements
- R1: After reset, `eps` is 209715 (0.0125 as a 24-bit fraction, that is floor(50·2^24/4000)), `upd_flag`, `oor_flag` and `busy` are 0, and the crossing count is 100.
- R2: A window opens at a reference crossing and closes on the N-th crossing after it. No result appears before that crossing, and one result appears shortly after it. Here N is the stored crossing count, which is 100 after reset.
- R3: The result is floor(N·2^24 / (2·S)), where S is the number of valid samples from the reference crossing sample, not counted, up to and including the closing crossing sample. Cycles with `s_valid` low are not counted.
- R4: A crossing is a change of the sign bit (bit 15 of `s_data`) between two consecutive valid samples. A sample of value 0 counts as non-negative, and magnitude changes within one sign are not crossings.
- R5: `busy` is high for exactly 24 consecutive cycles per division. `eps` and the flags change only after `busy` has fallen.
- R6: A result below 167772 (floor(40·2^24/4000)) or above 314572 (floor(75·2^24/4000)) leaves `eps` unchanged, sets `oor_flag` and does not set `upd_flag`. The bounds themselves are accepted.
- R7: `upd_flag` and `oor_flag` stay set until a one-cycle pulse on `upd_clr` or `oor_clr` clears them in the next cycle.
- R8: While `afc_en` is 0, no measurement runs and `eps` and both flags keep their values. Raising `afc_en` starts a fresh window, and the first valid sample after the rise is not compared with any earlier sample.
- R9: A pulse on `zxn_wr` stores `zxn_wdata` as the crossing count (a written 0 is stored as 1) and aborts the window and any division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Marks a new voltage sample |
| s_data | input | 16 | Signed voltage sample |
| afc_en | input | 1 | Enables the frequency measurement |
| zxn_wr | input | 1 | Write strobe for the crossing count |
| zxn_wdata | input | 16 | New crossing count |
| upd_clr | input | 1 | Clears `upd_flag` (write-one-to-clear) |
| oor_clr | input | 1 | Clears `oor_flag` (write-one-to-clear) |
| eps | output | 24 | Line frequency divided by sample rate, as an unsigned fraction |
| upd_flag | output | 1 | Sticky flag: a new in-band result was written |
| oor_flag | output | 1 | Sticky flag: the last result was out of band and was dropped |
| busy | output | 1 | The divider is running |

## Verification
The hardest case to reach from the ports is a window aborted partway through. Without the abort, the window's crossings and samples would blend into a quite different quotient. The stimulus writes the count after two half periods of one length, then continues with half periods of another length. The expected value holds only if counting restarted at the first crossing after the write. The exclusion of idle cycles, and the rule that a zero sample counts as non-negative, are also hard to observe. To reach them, strobes are spaced with gaps and positive half periods are fed as exact zeros, with uneven half-period lengths, so that any miscount shifts the quotient.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

  typedef enum logic [1:0] {
    W_IDLE,
    W_ARM,
    W_COUNT,
    W_WAIT
  } win_state_t;

endpackage

// File: rtl/lfe_zx_detect.sv
module lfe_zx_detect #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                zx_valid,
  output logic                zx_hit
);

  logic prev_neg;
  logic have_prev;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prev_neg  <= 1'b0;
      have_prev <= 1'b0;
      zx_valid  <= 1'b0;
      zx_hit    <= 1'b0;
    end else begin
      zx_valid <= s_valid;
      zx_hit   <= s_valid && have_prev && (s_data[SAMPLE_W-1] != prev_neg);
      if (s_valid) begin
        prev_neg  <= s_data[SAMPLE_W-1];
        have_prev <= 1'b1;
      end
    end
  end

  // a crossing is only reported for a strobed sample
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    zx_hit |-> zx_valid); // R4

endmodule

// File: rtl/lfe_window.sv
module lfe_window
  import lfe_pkg::*;
#(
  parameter int ZXN_W = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             abort,
  input  logic             zx_valid,
  input  logic             zx_hit,
  input  logic [ZXN_W-1:0] zx_num,
  input  logic             div_done,
  output logic             start,
  output logic [CNT_W-1:0] s_total
);

  win_state_t       state;
  logic [ZXN_W-1:0] zcnt;
  logic [CNT_W-1:0] scnt;
  logic [CNT_W-1:0] scnt_nxt;
  logic             last_zx;

  always_comb begin
    scnt_nxt = scnt + CNT_W'(1);
    last_zx  = (zcnt == zx_num - ZXN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= W_IDLE;
      zcnt    <= '0;
      scnt    <= '0;
      s_total <= '0;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!en) begin
        state <= W_IDLE;
      end else if (abort) begin
        state <= W_ARM;
      end else begin
        case (state)
          W_IDLE: state <= W_ARM;
          W_ARM: begin
            if (zx_valid && zx_hit) begin
              zcnt  <= '0;
              scnt  <= '0;
              state <= W_COUNT;
            end
          end
          W_COUNT: begin
            if (zx_valid) begin
              if (scnt == '1) begin
                // sample counter would wrap: drop this window
                state <= W_ARM;
              end else begin
                scnt <= scnt_nxt;
                if (zx_hit) begin
                  if (last_zx) begin
                    s_total <= scnt_nxt;
                    start   <= 1'b1;
                    state   <= W_WAIT;
                  end else begin
                    zcnt <= zcnt + ZXN_W'(1);
                  end
                end
              end
            end
          end
          W_WAIT: begin
            if (div_done) state <= W_ARM;
          end
          default: state <= W_IDLE;
        endcase
      end
    end
  end

  AST_ZCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == W_COUNT) |-> (zcnt < zx_num)); // R2

  AST_START_NONZERO: assert property (@(posedge clk) disable iff (rst)
    start |-> (s_total != '0)); // R3

endmodule

// File: rtl/lfe_divider.sv
module lfe_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 25,
  parameter int Q_W   = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);

  localparam int ITER_W = $clog2(Q_W + 1);

  logic [DEN_W-1:0]  rem;
  logic [DEN_W-1:0]  den_q;
  logic [ITER_W-1:0] iter;
  logic [DEN_W:0]    rem_sh;
  logic              take;
  logic [DEN_W-1:0]  rem_sub;

  always_comb begin
    rem_sh  = {rem, 1'b0};
    take    = (rem_sh >= {1'b0, den_q});
    rem_sub = rem_sh[DEN_W-1:0] - den_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rem   <= '0;
      den_q <= '0;
      iter  <= '0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        iter <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        rem   <= DEN_W'(num);
        den_q <= den;
        iter  <= ITER_W'(Q_W);
        quot  <= '0;
      end else if (busy) begin
        rem  <= take ? rem_sub : rem_sh[DEN_W-1:0];
        quot <= {quot[Q_W-2:0], take};
        iter <= iter - ITER_W'(1);
        if (iter == ITER_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < den_q)); // R3

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R5

endmodule

// File: rtl/line_freq_est.sv
module line_freq_est #(
  parameter int SAMPLE_W  = 16,
  parameter int EPS_W     = 24,
  parameter int ZXN_W     = 16,
  parameter int CNT_W     = 24,
  parameter int ZXN_RESET = 100,
  parameter int OWR_HZ    = 4000,
  parameter int F_RST_HZ  = 50,
  parameter int F_MIN_HZ  = 40,
  parameter int F_MAX_HZ  = 75
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                afc_en,
  input  logic                zxn_wr,
  input  logic [ZXN_W-1:0]    zxn_wdata,
  input  logic                upd_clr,
  input  logic                oor_clr,
  output logic [EPS_W-1:0]    eps,
  output logic                upd_flag,
  output logic                oor_flag,
  output logic                busy
);

  localparam int DEN_W = CNT_W + 1;
  localparam logic [63:0] ONE_FRAC = 64'd1 << EPS_W;
  localparam logic [63:0] EPS_RST_W = (64'(F_RST_HZ) * ONE_FRAC) / 64'(OWR_HZ);
  localparam logic [63:0] EPS_MIN_W = (64'(F_MIN_HZ) * ONE_FRAC) / 64'(OWR_HZ);
  localparam logic [63:0] EPS_MAX_W = (64'(F_MAX_HZ) * ONE_FRAC) / 64'(OWR_HZ);
  localparam logic [EPS_W-1:0] EPS_RST = EPS_RST_W[EPS_W-1:0];
  localparam logic [EPS_W-1:0] EPS_MIN = EPS_MIN_W[EPS_W-1:0];
  localparam logic [EPS_W-1:0] EPS_MAX = EPS_MAX_W[EPS_W-1:0];

  logic             afc_q;
  logic [ZXN_W-1:0] zxn_q;
  logic             abort;
  logic             zx_valid;
  logic             zx_hit;
  logic             win_start;
  logic [CNT_W-1:0] s_total;
  logic             div_done;
  logic [EPS_W-1:0] quot;
  logic             accept;
  logic             in_band;

  always_comb begin
    abort   = zxn_wr || (afc_en != afc_q);
    in_band = (quot >= EPS_MIN) && (quot <= EPS_MAX);
    accept  = div_done && afc_en && !abort;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      afc_q <= 1'b0;
      zxn_q <= ZXN_W'(ZXN_RESET);
    end else begin
      afc_q <= afc_en;
      if (zxn_wr) zxn_q <= (zxn_wdata == '0) ? ZXN_W'(1) : zxn_wdata;
    end
  end

  lfe_zx_detect #(
    .SAMPLE_W(SAMPLE_W)
  ) u_zx (
    .clk     (clk),
    .rst     (rst),
    .en      (afc_en),
    .s_valid (s_valid),
    .s_data  (s_data),
    .zx_valid(zx_valid),
    .zx_hit  (zx_hit)
  );

  lfe_window #(
    .ZXN_W(ZXN_W),
    .CNT_W(CNT_W)
  ) u_win (
    .clk     (clk),
    .rst     (rst),
    .en      (afc_en),
    .abort   (abort),
    .zx_valid(zx_valid),
    .zx_hit  (zx_hit),
    .zx_num  (zxn_q),
    .div_done(div_done),
    .start   (win_start),
    .s_total (s_total)
  );

  lfe_divider #(
    .NUM_W(ZXN_W),
    .DEN_W(DEN_W),
    .Q_W  (EPS_W)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .abort(abort),
    .start(win_start),
    .num  (zxn_q),
    .den  ({s_total, 1'b0}),
    .busy (busy),
    .done (div_done),
    .quot (quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eps      <= EPS_RST;
      upd_flag <= 1'b0;
      oor_flag <= 1'b0;
    end else begin
      if (accept && in_band) eps <= quot;

      if (accept && in_band) upd_flag <= 1'b1;
      else if (upd_clr)      upd_flag <= 1'b0;

      if (accept && !in_band) oor_flag <= 1'b1;
      else if (oor_clr)       oor_flag <= 1'b0;
    end
  end

  AST_EPS_IN_BAND: assert property (@(posedge clk) disable iff (rst)
    !$stable(eps) |-> ((eps >= EPS_MIN) && (eps <= EPS_MAX))); // R6

  AST_OOR_KEEPS_EPS: assert property (@(posedge clk) disable iff (rst)
    $rose(oor_flag) |-> ($stable(eps) && !$rose(upd_flag))); // R6

  AST_EPS_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !afc_en |=> $stable(eps)); // R8

  AST_UPD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (upd_flag && !upd_clr) |=> upd_flag); // R7

  AST_OOR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (oor_flag && !oor_clr) |=> oor_flag); // R7

  AST_NO_CHANGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(eps)); // R5

endmodule

// File: tb/sim_line_freq_est.sv
`timescale 1ns/1ps
module sim_line_freq_est;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        afc_en = 1'b1;
  logic        zxn_wr = 1'b0;
  logic [15:0] zxn_wdata = '0;
  logic        upd_clr = 1'b0;
  logic        oor_clr = 1'b0;
  logic [23:0] eps;
  logic        upd_flag;
  logic        oor_flag;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit pos = 1'b1;
  bit finished = 1'b0;
  int cur_run = 0;
  int last_run = 0;
  logic [23:0] held;

  always #4 clk = ~clk;

  line_freq_est u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data),
    .afc_en(afc_en), .zxn_wr(zxn_wr), .zxn_wdata(zxn_wdata),
    .upd_clr(upd_clr), .oor_clr(oor_clr), .eps(eps),
    .upd_flag(upd_flag), .oor_flag(oor_flag), .busy(busy)
  );

  always @(negedge clk) begin
    if (busy) cur_run = cur_run + 1;
    else if (cur_run > 0) begin
      last_run = cur_run;
      cur_run = 0;
    end
  end

  function automatic longint exp_eps(longint n, longint s);
    return (n << 24) / (2 * s);
  endfunction

  task automatic check(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  // one half period of h valid samples; zero_pos feeds 0 for the positive half
  task automatic feed_half(int h, bit gap, bit zero_pos);
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      if (pos) s_data = zero_pos ? 16'd0 : 16'(1000 + 7 * i);
      else     s_data = -16'(900 + 5 * i);
      if (gap) begin
        @(negedge clk);
        s_valid = 1'b0;
      end
    end
    pos = !pos;
  endtask

  task automatic feed(int halves, int h, bit gap);
    for (int k = 0; k < halves; k++) feed_half(h, gap, 1'b0);
    idle(1);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    upd_clr = 1'b1;
    oor_clr = 1'b1;
    @(negedge clk);
    upd_clr = 1'b0;
    oor_clr = 1'b0;
  endtask

  task automatic set_n(int n);
    idle(5);
    @(negedge clk);
    zxn_wr = 1'b1;
    zxn_wdata = 16'(n);
    @(negedge clk);
    zxn_wr = 1'b0;
    clear_flags();
  endtask

  task automatic wait_flags();
    for (int i = 0; i < 400; i++) begin
      if (upd_flag || oor_flag) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 eps reset", eps, 209715);
    check("R1 upd reset", upd_flag, 0);
    check("R1 oor reset", oor_flag, 0);
    check("R1 busy reset", busy, 0);
  endtask

  task automatic t_default_count();
    feed_half(33, 1'b0, 1'b0);       // primes the sign history
    feed(100, 33, 1'b0);             // reference plus 99 crossings
    idle(60);
    check("R2 no result before 100th crossing", upd_flag, 0);
    feed(2, 33, 1'b0);
    wait_flags();
    check("R2 result after 100th crossing (R1 count reset)", upd_flag, 1);
    check("R3 eps for H=33 N=100", eps, exp_eps(100, 3300));
  endtask

  task automatic t_sticky();
    idle(30);
    check("R7 upd stays set", upd_flag, 1);
    @(negedge clk);
    upd_clr = 1'b1;
    @(negedge clk);
    upd_clr = 1'b0;
    check("R7 upd cleared by pulse", upd_flag, 0);
  endtask

  task automatic t_uneven_zero();
    set_n(6);
    for (int k = 0; k < 8; k++) feed_half((k % 2 == 0) ? 40 : 41, 1'b0, 1'b1);
    idle(1);
    wait_flags();
    check("R4 zero-valued uneven halves", eps, exp_eps(6, 243));
  endtask

  task automatic t_gaps();
    set_n(4);
    feed(6, 30, 1'b1);
    wait_flags();
    check("R3 idle cycles not counted", eps, exp_eps(4, 120));
  endtask

  task automatic t_abort();
    set_n(4);
    feed(2, 40, 1'b0);
    set_n(4);
    feed(6, 28, 1'b0);
    wait_flags();
    check("R9 write aborts window", eps, exp_eps(4, 112));
  endtask

  task automatic t_zero_count();
    set_n(0);
    feed(3, 35, 1'b0);
    wait_flags();
    check("R9 count 0 stored as 1", eps, exp_eps(1, 35));
  endtask

  task automatic t_busy();
    set_n(4);
    last_run = 0;
    feed(6, 45, 1'b0);
    wait_flags();
    check("R5 busy length", last_run, 24);
    check("R5 busy low at update", busy, 0);
    check("R5 eps H=45", eps, exp_eps(4, 180));
  endtask

  task automatic t_oor();
    held = eps;
    set_n(4);
    feed(6, 20, 1'b0);
    wait_flags();
    check("R6 high oor flag", oor_flag, 1);
    check("R6 high no upd", upd_flag, 0);
    check("R6 high eps kept", eps, held);
    set_n(4);
    feed(6, 60, 1'b0);
    wait_flags();
    check("R6 low oor flag", oor_flag, 1);
    check("R6 low no upd", upd_flag, 0);
    check("R6 low eps kept", eps, held);
  endtask

  task automatic t_bounds();
    set_n(4);
    feed(6, 50, 1'b0);
    wait_flags();
    check("R6 lower bound accepted", eps, 167772);
    check("R6 lower bound upd", upd_flag, 1);
    set_n(4);
    feed(6, 27, 1'b0);
    wait_flags();
    check("R6 near upper bound accepted", eps, exp_eps(4, 108));
    check("R6 near upper no oor", oor_flag, 0);
  endtask

  task automatic t_disable();
    held = eps;
    @(negedge clk);
    afc_en = 1'b0;
    idle(3);
    clear_flags();
    feed(8, 30, 1'b0);
    idle(40);
    check("R8 eps held while off", eps, held);
    check("R8 no upd while off", upd_flag, 0);
    check("R8 no oor while off", oor_flag, 0);
    @(negedge clk);
    afc_en = 1'b1;
    idle(3);
    feed(7, 36, 1'b0);
    wait_flags();
    check("R8 measure after re-enable", eps, exp_eps(4, 144));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default_count();
    t_sticky();
    t_uneven_zero();
    t_gaps();
    t_abort();
    t_zero_count();
    t_busy();
    t_oor();
    t_bounds();
    t_disable();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule